// File: doc/BRIEF.md
# Bit-oriented HDLC/SDLC frame receiver

This block receives a bit-oriented link layer stream one bit at a time and turns it into octets. A strobe marks each cycle that carries a line bit. The receiver discards everything until it sees the frame delimiter (one 0, six 1s, one 0). It deletes the 0 that a transmitter inserts after five 1s and assembles the remaining bits into octets, least significant bit first. It then decides from the first octet whether the frame is meant for this station. An accepted frame leaves the block as a byte stream: the control octet comes first, tagged with a start marker, and the information octets follow. The two octets that carry the 16-bit check sequence are held back and never presented as data. The closing delimiter produces an end marker together with a good or error status.

The block also watches the length of runs of 1s. A run of seven 1s inside a frame aborts that frame, and the receiver goes back to hunting for a delimiter. A run of fifteen or more 1s marks the line as idle until the next 0 arrives. The station address is a static input, and the all-ones address is accepted by every station.

Top module: `sdlc_deframer`

## Requirements
- R1: After reset, and after an abort, no byte, start marker, end marker or status is produced until a delimiter 01111110 has been received. Bits that arrive before that delimiter, including runs of up to fourteen 1s, have no effect on the outputs.
- R2: Every delimiter closes the current frame and opens a new one, so a single delimiter may close one frame and open the next. Two delimiters with no octet between them produce no end marker.
- R3: Inside a frame, a 0 that follows exactly five consecutive 1s is discarded. It is neither shifted into an octet nor included in the check sequence.
- R4: Octets are assembled least significant bit first. The address octet is not output. The control octet and the information octets appear on byte_out in order, each with a one-cycle byte_vld, and sof is high together with the control octet only.
- R5: A frame is accepted only when its first octet equals station_addr or equals 0xFF. Any other frame produces no bytes and no end marker.
- R6: The last two octets before the closing delimiter (the check sequence) are never presented on byte_out. A data octet is released only once two later octets of the same frame have completed.
- R7: The check register is preset to 0xFFFF and updated bit by bit, least significant bit first, with the polynomial x^16+x^12+x^5+1 (reversed constant 0x8408). The register covers every octet of the frame, including the check octets, which the sender transmits as the complement of its register, low octet first. When an accepted frame closes, eof pulses, and frame_ok pulses with it if the register holds 0xF0B8.
- R8: At the close of an accepted frame, crc_err pulses together with eof instead of frame_ok when the check fails, when the frame holds fewer than four octets, or when its bit count between delimiters is not a multiple of eight. Exactly one of frame_ok and crc_err accompanies each eof, and neither appears without it.
- R9: The seventh consecutive 1 received inside a frame raises abort_pulse for one cycle. The frame is dropped with no end marker, and the receiver hunts for the next delimiter.
- R10: idle rises on the fifteenth consecutive 1 and stays high until a 0 is received.
- R11: All outputs are registered. Each reacts in the cycle after the strobed bit that causes it, the pulse outputs last one cycle, and every output is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_in | input | 1 | Received line bit |
| bit_vld | input | 1 | bit_in carries a line bit in this cycle |
| station_addr | input | 8 | This station's address, static |
| byte_out | output | 8 | Recovered data octet |
| byte_vld | output | 1 | byte_out valid, one cycle |
| sof | output | 1 | First data octet (the control octet) of a frame |
| eof | output | 1 | Accepted frame closed, one cycle |
| frame_ok | output | 1 | Frame passed the check, with eof |
| crc_err | output | 1 | Frame failed the check or length rules, with eof |
| abort_pulse | output | 1 | Seven 1s in a row inside a frame, one cycle |
| idle | output | 1 | Fifteen or more 1s seen, held until a 0 |

## Verification
The stream is tried with several patterns, each of which separates a different behaviour. Garbage and a ten-1 run before any delimiter separate true hunting from early framing. Back-to-back and shared delimiters separate closing from opening. Payload octets 0x7E, 0xFF, 0xF8 and 0x1F force zero deletion both inside octets and across octet borders. Frames to this station, to the all-ones address and to a foreign address separate the accept rule from the reject rule. A corrupted check, a three-octet frame and a frame with three trailing bits each drive the error status by a different route. A seven-1 abort that grows into a twenty-1 idle run separates the abort threshold from the idle threshold. Bits are fed both on every cycle and on every second cycle, so that the pulse lengths and the one-cycle latency can be told apart from the strobe pattern.

// File: rtl/sdlc_pkg.sv
package sdlc_pkg;
  localparam int          OCTET_W    = 8;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_R = 16'h8408;
  localparam logic [15:0] CRC_GOOD   = 16'hF0B8;

  // One LSB-first step of the reflected CCITT check register.
  function automatic logic [15:0] crc16_step(input logic [15:0] crc, input logic b);
    logic fb;
    fb = crc[0] ^ b;
    crc16_step = fb ? ((crc >> 1) ^ CRC_POLY_R) : (crc >> 1);
  endfunction

  function automatic logic addr_accept(input logic [OCTET_W-1:0] a,
                                       input logic [OCTET_W-1:0] own);
    addr_accept = (a == own) || (a == {OCTET_W{1'b1}});
  endfunction
endpackage

// File: rtl/sdlc_run_detect.sv
module sdlc_run_detect #(
  parameter int STUFF_RUN = 5,
  parameter int IDLE_RUN  = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in,
  input  logic bit_vld,
  output logic ev_flag,
  output logic ev_stuff,
  output logic ev_seven,
  output logic data_push,
  output logic idle
);
  localparam int ONES_W = $clog2(IDLE_RUN + 1);
  localparam logic [ONES_W-1:0] K_STUFF = ONES_W'(STUFF_RUN);
  localparam logic [ONES_W-1:0] K_FLAG  = ONES_W'(STUFF_RUN + 1);
  localparam logic [ONES_W-1:0] K_IDLE1 = ONES_W'(IDLE_RUN - 1);
  localparam logic [ONES_W-1:0] K_SAT   = ONES_W'(IDLE_RUN);

  logic [ONES_W-1:0] ones;

  assign ev_flag   = bit_vld && !bit_in && (ones == K_FLAG);
  assign ev_stuff  = bit_vld && !bit_in && (ones == K_STUFF);
  assign ev_seven  = bit_vld &&  bit_in && (ones == K_FLAG);
  assign data_push = bit_vld && (bit_in ? (ones < K_STUFF)
                                        : ((ones != K_STUFF) && (ones != K_FLAG)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones <= '0;
      idle <= 1'b0;
    end else if (bit_vld) begin
      if (bit_in) begin
        if (ones != K_SAT) ones <= ones + 1'b1;
        if (ones == K_IDLE1) idle <= 1'b1;
      end else begin
        ones <= '0;
        idle <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sdlc_bit_delay.sv
module sdlc_bit_delay #(
  parameter int DEPTH = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic push,
  input  logic d,
  output logic commit,
  output logic c_bit
);
  localparam int FILL_W = $clog2(DEPTH + 1);
  localparam logic [FILL_W-1:0] K_FULL = FILL_W'(DEPTH);

  logic [DEPTH-1:0]  line;
  logic [FILL_W-1:0] fill;

  assign commit = push && (fill == K_FULL);
  assign c_bit  = line[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line <= '0;
      fill <= '0;
    end else if (clr) begin
      fill <= '0;
    end else if (push) begin
      if (fill == K_FULL) begin
        line <= {d, line[DEPTH-1:1]};
      end else begin
        line[fill] <= d;
        fill       <= fill + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdlc_crc16.sv
module sdlc_crc16 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        en,
  input  logic        d,
  output logic [15:0] crc
);
  import sdlc_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc <= CRC_PRESET;
    else if (init) crc <= CRC_PRESET;
    else if (en)   crc <= crc16_step(crc, d);
  end
endmodule

// File: rtl/sdlc_deframer.sv
module sdlc_deframer #(
  parameter int STUFF_RUN = 5,
  parameter int IDLE_RUN  = 15,
  parameter int OCT_CNT_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_in,
  input  logic       bit_vld,
  input  logic [7:0] station_addr,
  output logic [7:0] byte_out,
  output logic       byte_vld,
  output logic       sof,
  output logic       eof,
  output logic       frame_ok,
  output logic       crc_err,
  output logic       abort_pulse,
  output logic       idle
);
  import sdlc_pkg::*;

  localparam int HOLD_DEPTH = STUFF_RUN + 1;
  localparam logic [OCT_CNT_W-1:0] OCT_MAX   = {OCT_CNT_W{1'b1}};
  localparam logic [OCT_CNT_W-1:0] OCT_FIRST = OCT_CNT_W'(3);
  localparam logic [OCT_CNT_W-1:0] OCT_MIN   = OCT_CNT_W'(4);

  // named internal events
  logic ev_flag, ev_stuff, ev_seven, data_push;
  logic commit, c_bit, commit_in, oct_done, frame_close;
  logic fcs_ok, len_ok;
  logic [15:0] crc;

  logic                 in_frame, match;
  logic [2:0]           bitcnt;
  logic [OCTET_W-2:0]   shreg;
  logic [OCT_CNT_W-1:0] oct_cnt;
  logic [OCTET_W-1:0]   hold0, hold1, new_byte;

  sdlc_run_detect #(.STUFF_RUN(STUFF_RUN), .IDLE_RUN(IDLE_RUN)) u_run (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
    .ev_flag(ev_flag), .ev_stuff(ev_stuff), .ev_seven(ev_seven),
    .data_push(data_push), .idle(idle)
  );

  sdlc_bit_delay #(.DEPTH(HOLD_DEPTH)) u_dly (
    .clk(clk), .rst_n(rst_n), .clr(ev_flag), .push(data_push && in_frame),
    .d(bit_in), .commit(commit), .c_bit(c_bit)
  );

  sdlc_crc16 u_crc (
    .clk(clk), .rst_n(rst_n), .init(ev_flag), .en(commit_in), .d(c_bit), .crc(crc)
  );

  assign commit_in   = commit && in_frame;
  assign new_byte    = {c_bit, shreg};
  assign oct_done    = commit_in && (bitcnt == 3'd7);
  assign frame_close = ev_flag && in_frame && match;
  assign fcs_ok      = (crc == CRC_GOOD);
  assign len_ok      = (bitcnt == 3'd0) && (oct_cnt >= OCT_MIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0; match <= 1'b0; bitcnt <= '0; shreg <= '0; oct_cnt <= '0;
      hold0 <= '0; hold1 <= '0; byte_out <= '0; byte_vld <= 1'b0; sof <= 1'b0;
      eof <= 1'b0; frame_ok <= 1'b0; crc_err <= 1'b0; abort_pulse <= 1'b0;
    end else begin
      byte_vld <= 1'b0; sof <= 1'b0; eof <= 1'b0;
      frame_ok <= 1'b0; crc_err <= 1'b0; abort_pulse <= 1'b0;
      if (ev_flag) begin
        in_frame <= 1'b1;
        match    <= 1'b0;
        bitcnt   <= '0;
        oct_cnt  <= '0;
        if (frame_close) begin
          eof      <= 1'b1;
          frame_ok <= fcs_ok && len_ok;
          crc_err  <= !(fcs_ok && len_ok);
        end
      end else if (ev_seven && in_frame) begin
        in_frame    <= 1'b0;
        match       <= 1'b0;
        abort_pulse <= 1'b1;
      end else if (commit_in) begin
        shreg  <= new_byte[OCTET_W-1:1];
        bitcnt <= bitcnt + 1'b1;
        if (oct_done) begin
          if (oct_cnt != OCT_MAX) oct_cnt <= oct_cnt + 1'b1;
          hold0 <= new_byte;
          hold1 <= hold0;
          if (oct_cnt == '0) match <= addr_accept(new_byte, station_addr);
          if ((oct_cnt >= OCT_FIRST) && match) begin
            byte_out <= hold1;
            byte_vld <= 1'b1;
            sof      <= (oct_cnt == OCT_FIRST);
          end
        end
      end
    end
  end
endmodule

// File: rtl/sdlc_deframer_chk.sv
module sdlc_deframer_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_in,
  input logic bit_vld,
  input logic byte_vld,
  input logic sof,
  input logic eof,
  input logic frame_ok,
  input logic crc_err,
  input logic abort_pulse,
  input logic idle,
  input logic ev_flag,
  input logic ev_stuff,
  input logic data_push,
  input logic in_frame
);
  a_r3_stuff_not_pushed: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stuff |-> !data_push);
  a_r4_sof_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
    sof |-> byte_vld);
  a_r7_one_status: assert property (@(posedge clk) disable iff (!rst_n)
    eof |-> ($countones({frame_ok, crc_err}) == 1));
  a_r8_status_needs_eof: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok || crc_err) |-> eof);
  a_r2_flag_opens: assert property (@(posedge clk) disable iff (!rst_n)
    ev_flag |=> in_frame);
  a_r9_abort_leaves_frame: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> !in_frame);
  a_r10_idle_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle) |-> $past(bit_vld && bit_in));
  a_r10_idle_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle) |-> $past(bit_vld && !bit_in));
  a_r11_quiet_without_bit: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_vld) |-> !(byte_vld || eof || abort_pulse));
endmodule

bind sdlc_deframer sdlc_deframer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
  .byte_vld(byte_vld), .sof(sof), .eof(eof), .frame_ok(frame_ok),
  .crc_err(crc_err), .abort_pulse(abort_pulse), .idle(idle),
  .ev_flag(ev_flag), .ev_stuff(ev_stuff), .data_push(data_push),
  .in_frame(in_frame)
);

// File: tb/sdlc_deframer_bench.sv
module sdlc_deframer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_in = 1'b0;
  logic       bit_vld = 1'b0;
  logic [7:0] station_addr = 8'h5A;
  logic [7:0] byte_out;
  logic       byte_vld, sof, eof, frame_ok, crc_err, abort_pulse, idle;

  always #2 clk = ~clk;

  sdlc_deframer u_sdlc_deframer (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
    .station_addr(station_addr), .byte_out(byte_out), .byte_vld(byte_vld),
    .sof(sof), .eof(eof), .frame_ok(frame_ok), .crc_err(crc_err),
    .abort_pulse(abort_pulse), .idle(idle)
  );

  int tests = 0, fails = 0;
  bit done = 0;

  // ---------------- behavioural reference ----------------
  int   m_ones, m_nbits;
  bit   m_inf, m_match;
  bit   m_q[$];
  byte  m_octs[$];
  bit [7:0] m_cur;
  bit [7:0] x_byte;
  bit   x_bv, x_sof, x_eof, x_ok, x_err, x_abort, x_idle;

  function automatic bit [15:0] crc_bytes(input byte b[$]);
    bit [15:0] c = 16'hFFFF;
    foreach (b[i]) begin
      c ^= {8'h00, b[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    end
    return c;
  endfunction

  task automatic m_commit(input bit c);
    m_cur[m_nbits % 8] = c;
    m_nbits++;
    if (m_nbits % 8 == 0) begin
      m_octs.push_back(m_cur);
      if (m_octs.size() == 1) m_match = (m_cur == station_addr) || (m_cur == 8'hFF);
      if (m_octs.size() >= 4 && m_match) begin
        x_bv = 1; x_byte = m_octs[m_octs.size() - 3];
        x_sof = (m_octs.size() == 4);
      end
    end
  endtask

  task automatic m_push(input bit d);
    m_q.push_back(d);
    if (m_q.size() > 6) m_commit(m_q.pop_front());
  endtask

  task automatic m_step(input bit b);
    if (b) begin
      m_ones++;
      if (m_ones == 7 && m_inf) begin x_abort = 1; m_inf = 0; m_match = 0; end
      if (m_ones == 15) x_idle = 1;
      if (m_ones <= 5 && m_inf) m_push(1);
    end else begin
      if (m_ones == 6) begin
        if (m_inf && m_match) begin
          bit good;
          good = (m_nbits % 8 == 0) && (m_octs.size() >= 4) &&
                 (crc_bytes(m_octs) == 16'hF0B8);
          x_eof = 1; x_ok = good; x_err = !good;
        end
        m_inf = 1; m_match = 0; m_q.delete(); m_octs.delete(); m_nbits = 0;
      end else if (!(m_ones == 5 && m_inf)) begin
        if (m_inf) m_push(0);
      end
      m_ones = 0; x_idle = 0;
    end
  endtask

  always @(posedge clk) begin
    x_bv = 0; x_sof = 0; x_eof = 0; x_ok = 0; x_err = 0; x_abort = 0;
    if (!rst_n) begin
      m_ones = 0; m_nbits = 0; m_inf = 0; m_match = 0; x_idle = 0; x_byte = 0;
      m_q.delete(); m_octs.delete();
    end else if (bit_vld) m_step(bit_in);
  end

  // ---------------- per-clock comparison ----------------
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  int n_eof = 0, n_ok = 0, n_err = 0, n_bytes = 0, n_sof = 0, n_abort = 0, n_idle = 0;
  bit prev_idle = 0;
  byte seen[$];

  always @(negedge clk) if (!done) begin
    chk(byte_vld == x_bv,       "R4 byte_vld", byte_vld, x_bv);
    if (x_bv) chk(byte_out == x_byte, "R6 byte_out", byte_out, x_byte);
    chk(sof == x_sof,           "R4 sof", sof, x_sof);
    chk(eof == x_eof,           "R5 eof", eof, x_eof);
    chk(frame_ok == x_ok,       "R7 frame_ok", frame_ok, x_ok);
    chk(crc_err == x_err,       "R8 crc_err", crc_err, x_err);
    chk(abort_pulse == x_abort, "R9 abort_pulse", abort_pulse, x_abort);
    chk(idle == x_idle,         "R10 idle", idle, x_idle);
    if (byte_vld) begin n_bytes++; seen.push_back(byte_out); end
    n_sof += sof; n_eof += eof; n_ok += frame_ok; n_err += crc_err; n_abort += abort_pulse;
    if (idle && !prev_idle) n_idle++;
    prev_idle = idle;
  end

  // ---------------- stimulus ----------------
  int gap = 1;
  int tx_ones = 0;

  task automatic send_bit(input bit b);
    @(negedge clk); bit_in = b; bit_vld = 1;
    repeat (gap) begin @(negedge clk); bit_vld = 0; end
  endtask

  task automatic send_raw(input bit b);
    send_bit(b);
    tx_ones = 0;
  endtask

  task automatic send_flag();
    send_bit(0); repeat (6) send_bit(1); send_bit(0);
    tx_ones = 0;
  endtask

  task automatic send_data_bit(input bit b);
    send_bit(b);
    if (b) begin
      tx_ones++;
      if (tx_ones == 5) begin send_bit(0); tx_ones = 0; end
    end else tx_ones = 0;
  endtask

  task automatic send_byte(input byte v);
    for (int i = 0; i < 8; i++) send_data_bit(v[i]);
  endtask

  task automatic send_frame(input byte f[$], input bit corrupt);
    bit [15:0] fcs;
    fcs = ~crc_bytes(f);
    if (corrupt) fcs ^= 16'h0001;
    foreach (f[i]) send_byte(f[i]);
    send_byte(fcs[7:0]);
    send_byte(fcs[15:8]);
  endtask

  task automatic settle();
    @(negedge clk); bit_vld = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(byte_vld == 0 && eof == 0 && idle == 0 && abort_pulse == 0, "R11 reset", byte_vld, 0);
    rst_n = 1;
    // R1: ten 1s and garbage before the first flag
    repeat (10) send_raw(1);
    send_raw(0); send_raw(1); send_raw(0); send_raw(1); send_raw(1); send_raw(0);
    settle();
    chk(n_bytes == 0 && n_eof == 0 && n_abort == 0, "R1 hunting", n_bytes + n_eof, 0);
    // R2: two delimiters, nothing between
    send_flag(); send_flag();
    settle();
    chk(n_eof == 0, "R2 empty frame", n_eof, 0);
    // R3/R4/R7: addressed frame with stuffing-heavy payload, back-to-back bits
    gap = 0;
    send_frame('{8'h5A, 8'h13, 8'h7E, 8'hFF, 8'h3E}, 0);
    send_flag();
    settle();
    chk(seen.size() == 4, "R4 byte count", seen.size(), 4);
    if (seen.size() == 4)
      chk(seen[0] == 8'h13 && seen[1] == 8'h7E && seen[2] == 8'hFF && seen[3] == 8'h3E,
          "R3 destuffed payload", seen[1], 8'h7E);
    chk(n_ok == 1, "R7 good frame", n_ok, 1);
    // R5: broadcast minimal frame sharing the previous closing flag
    gap = 1;
    send_frame('{8'hFF, 8'h00}, 0);
    send_flag();
    // foreign address
    send_frame('{8'h33, 8'h01, 8'h02}, 0);
    send_flag();
    settle();
    chk(n_eof == 2 && n_ok == 2, "R5 address filter", n_eof, 2);
    // R8: corrupt check, short frame, misaligned frame
    send_frame('{8'h5A, 8'h21, 8'h11}, 1);
    send_flag();
    send_byte(8'h5A); send_byte(8'h21); send_byte(8'h55);
    send_flag();
    send_frame('{8'h5A, 8'h31, 8'h22}, 0);
    send_raw(0); send_raw(1); send_raw(0);
    send_flag();
    settle();
    chk(n_err == 3 && n_ok == 2, "R8 error frames", n_err, 3);
    // R9/R10: abort that grows into idle
    gap = 0;
    send_byte(8'h5A); send_byte(8'h41); send_byte(8'h44); send_byte(8'h45); send_byte(8'h46);
    repeat (20) send_raw(1);
    settle();
    chk(n_abort == 1, "R9 abort", n_abort, 1);
    chk(idle == 1, "R10 idle held", idle, 1);
    send_raw(0);
    settle();
    chk(idle == 0 && n_idle == 1, "R10 idle cleared", idle, 0);
    // R1 after abort: recovery with a fresh frame
    gap = 1;
    send_flag();
    send_frame('{8'h5A, 8'hAA, 8'hF8, 8'h1F}, 0);
    send_flag();
    settle();
    chk(n_ok == 3 && n_eof == 6, "R2 recovery frame", n_eof, 6);
    chk(n_bytes == 13, "R6 total data bytes", n_bytes, 13);
    chk(n_sof == 6, "R4 start markers", n_sof, 6);
    chk(n_abort == 1, "R11 single abort pulse", n_abort, 1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule